// File: doc/BRIEF.md
# USB Device Endpoint Handshake Controller

This block keeps the handshake state of one endpoint of a full-speed USB device. It holds a receive status and a transmit status, the two data-toggle bits, a correct-receive flag, a setup flag and the byte count of the last good reception. A protocol engine reports what happened on the bus through single-cycle pulses: a token arrived, an OUT data stage completed, a SETUP data stage completed, or the reception failed because of a bus error or buffer overrun. For each OUT token, the block answers with the handshake that the engine should send.

After a good OUT, the endpoint holds off further OUT data by answering NAK until software re-arms it. After a good SETUP, the toggles are forced to fixed values and both directions answer NAK, so software can decide which direction the control transfer takes next. Software uses a small write interface to clear the correct-receive flag and to rewrite either status field.

Both status fields use the same 2-bit code: 00 DISABLED, 01 STALL, 10 NAK, 11 VALID. The handshake reply code is 00 none, 01 ACK, 10 NAK, 11 STALL.

Top module: `ep_handshake_ctrl`

## Requirements
- R1: While reset is held, both status fields read 00, both toggles read 0, both flags read 0, the byte count reads 0 and no reply is raised.
- R2: A good OUT completion means `ev_out_ok` is high and both `ev_setup_ok` and `ev_err` are low. One cycle after it, the receive toggle is inverted, the receive status is NAK (10), the correct-receive flag is 1 and the setup flag is 0. The transmit status and the transmit toggle are unchanged.
- R3: When `ev_err` is high, a completion pulse in the same cycle has no effect on the toggles, the statuses, the setup flag or the byte count. It also does not set the correct-receive flag.
- R4: A good SETUP completion means `ev_setup_ok` is high and `ev_err` is low. It takes priority over `ev_out_ok`. One cycle after it, the transmit toggle is 1 and the receive toggle is 0. Both statuses are NAK (10), and both the correct-receive flag and the setup flag are 1.
- R5: On every good completion, `rx_bytes` is captured into `rx_count`, visible one cycle later. At all other times, `rx_count` holds its value.
- R6: One cycle after `tok_out`, the reply depends on the receive status sampled with the token. VALID gives `reply_vld`=1 with code 01 (ACK). NAK gives code 10 (NAK). STALL gives code 11 (STALL). DISABLED gives `reply_vld`=0. Without a token, `reply_vld` is 0 and `reply_code` is 00.
- R7: A flag write with `sw_flag_bit`=0 clears the correct-receive flag, and one with `sw_flag_bit`=1 leaves it unchanged. If a good completion occurs in the same cycle as a clearing write, the flag ends up set.
- R8: `sw_rx_we` loads `sw_rx_stat` into the receive status, and `sw_tx_we` loads `sw_tx_stat` into the transmit status, each one cycle later. A good completion in the same cycle overrides the write for every status that the completion sets.
- R9: After a good OUT, every following OUT token is answered with NAK until software writes VALID to the receive status. The first token after that write is answered with ACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_out | input | 1 | OUT token addressed to this endpoint (pulse) |
| ev_out_ok | input | 1 | OUT data stage completed (pulse) |
| ev_setup_ok | input | 1 | SETUP data stage completed (pulse) |
| ev_err | input | 1 | Reception failed: bus error or overrun |
| rx_bytes | input | CNT_W | Byte count of the completing reception |
| sw_flag_we | input | 1 | Software write to correct-receive flag |
| sw_flag_bit | input | 1 | Written flag value (0 clears, 1 keeps) |
| sw_rx_we | input | 1 | Software write to receive status |
| sw_rx_stat | input | 2 | New receive status |
| sw_tx_we | input | 1 | Software write to transmit status |
| sw_tx_stat | input | 2 | New transmit status |
| reply_vld | output | 1 | Handshake reply present |
| reply_code | output | 2 | Reply: 00 none, 01 ACK, 10 NAK, 11 STALL |
| rx_stat | output | 2 | Receive status |
| tx_stat | output | 2 | Transmit status |
| rx_tog | output | 1 | Receive data toggle |
| tx_tog | output | 1 | Transmit data toggle |
| ctr_flag | output | 1 | Correct-receive flag |
| setup_flag | output | 1 | Last good reception was a SETUP |
| rx_count | output | CNT_W | Latched received byte count |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it. This applies to status, toggle, flag and count updates after a completion or a software write, and to the handshake reply after a token. The bench drives inputs at the falling edge. It advances a requirement-based model at the rising edge, using the same input values, and compares every output one nanosecond later. Each check therefore lands in the first cycle in which the new value must be visible. Directed cases cover back-to-back OUT tokens after a reception, errored completions, clashes between completions and software writes, and every status value under a token. A seeded random run then mixes all inputs.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;

    typedef enum logic [1:0] {
        ST_DISABLED = 2'b00,
        ST_STALL    = 2'b01,
        ST_NAK      = 2'b10,
        ST_VALID    = 2'b11
    } ep_stat_e;

    typedef enum logic [1:0] {
        RP_NONE  = 2'b00,
        RP_ACK   = 2'b01,
        RP_NAK   = 2'b10,
        RP_STALL = 2'b11
    } reply_e;

    typedef struct packed {
        ep_stat_e stat;
        logic     tog;
    } tx_ctl_t;

endpackage

// File: rtl/ep_rx_path.sv
module ep_rx_path
    import ep_hs_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             good_out,
    input  logic             good_setup,
    input  logic [CNT_W-1:0] bytes_in,
    input  logic             flag_we,
    input  logic             flag_bit,
    input  logic             stat_we,
    input  ep_stat_e         stat_wval,
    output ep_stat_e         stat,
    output logic             tog,
    output logic             ctr,
    output logic             setup,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        ep_stat_e         stat;
        logic             tog;
        logic             ctr;
        logic             setup;
        logic [CNT_W-1:0] count;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic      done;

    always_comb begin
        st_d = st_q;
        done = good_out || good_setup;
        if (stat_we) begin
            st_d.stat = stat_wval;
        end
        if (flag_we && !flag_bit) begin
            st_d.ctr = 1'b0;
        end
        if (done) begin
            st_d.stat  = ST_NAK;
            st_d.ctr   = 1'b1;
            st_d.setup = good_setup;
            st_d.count = bytes_in;
            st_d.tog   = good_setup ? 1'b0 : ~st_q.tog;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{stat: ST_DISABLED, tog: 1'b0, ctr: 1'b0, setup: 1'b0, count: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign stat  = st_q.stat;
    assign tog   = st_q.tog;
    assign ctr   = st_q.ctr;
    assign setup = st_q.setup;
    assign count = st_q.count;

endmodule

// File: rtl/ep_tx_path.sv
module ep_tx_path
    import ep_hs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     good_setup,
    input  logic     stat_we,
    input  ep_stat_e stat_wval,
    output ep_stat_e stat,
    output logic     tog
);

    tx_ctl_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (stat_we) begin
            tx_d.stat = stat_wval;
        end
        if (good_setup) begin
            tx_d.stat = ST_NAK;
            tx_d.tog  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '{stat: ST_DISABLED, tog: 1'b0};
        end else begin
            tx_q <= tx_d;
        end
    end

    assign stat = tx_q.stat;
    assign tog  = tx_q.tog;

endmodule

// File: rtl/ep_reply.sv
module ep_reply
    import ep_hs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tok,
    input  ep_stat_e rx_stat,
    output logic     vld,
    output reply_e   code
);

    typedef struct packed {
        logic   vld;
        reply_e code;
    } rep_t;

    rep_t rp_d, rp_q;

    always_comb begin
        rp_d = '{vld: 1'b0, code: RP_NONE};
        if (tok) begin
            unique case (rx_stat)
                ST_VALID:    rp_d = '{vld: 1'b1, code: RP_ACK};
                ST_NAK:      rp_d = '{vld: 1'b1, code: RP_NAK};
                ST_STALL:    rp_d = '{vld: 1'b1, code: RP_STALL};
                ST_DISABLED: rp_d = '{vld: 1'b0, code: RP_NONE};
                default:     rp_d = '{vld: 1'b0, code: RP_NONE};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_q <= '{vld: 1'b0, code: RP_NONE};
        end else begin
            rp_q <= rp_d;
        end
    end

    assign vld  = rp_q.vld;
    assign code = rp_q.code;

endmodule

// File: rtl/ep_handshake_ctrl.sv
module ep_handshake_ctrl
    import ep_hs_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_out,
    input  logic             ev_out_ok,
    input  logic             ev_setup_ok,
    input  logic             ev_err,
    input  logic [CNT_W-1:0] rx_bytes,
    input  logic             sw_flag_we,
    input  logic             sw_flag_bit,
    input  logic             sw_rx_we,
    input  logic [1:0]       sw_rx_stat,
    input  logic             sw_tx_we,
    input  logic [1:0]       sw_tx_stat,
    output logic             reply_vld,
    output logic [1:0]       reply_code,
    output logic [1:0]       rx_stat,
    output logic [1:0]       tx_stat,
    output logic             rx_tog,
    output logic             tx_tog,
    output logic             ctr_flag,
    output logic             setup_flag,
    output logic [CNT_W-1:0] rx_count
);

    logic     good_setup;
    logic     good_out;
    ep_stat_e rx_stat_w;
    ep_stat_e tx_stat_w;
    reply_e   code_w;

    // SETUP outranks OUT; an error voids either completion
    assign good_setup = ev_setup_ok && !ev_err;
    assign good_out   = ev_out_ok && !ev_setup_ok && !ev_err;

    ep_rx_path #(.CNT_W(CNT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .good_out  (good_out),
        .good_setup(good_setup),
        .bytes_in  (rx_bytes),
        .flag_we   (sw_flag_we),
        .flag_bit  (sw_flag_bit),
        .stat_we   (sw_rx_we),
        .stat_wval (ep_stat_e'(sw_rx_stat)),
        .stat      (rx_stat_w),
        .tog       (rx_tog),
        .ctr       (ctr_flag),
        .setup     (setup_flag),
        .count     (rx_count)
    );

    ep_tx_path u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .good_setup(good_setup),
        .stat_we   (sw_tx_we),
        .stat_wval (ep_stat_e'(sw_tx_stat)),
        .stat      (tx_stat_w),
        .tog       (tx_tog)
    );

    ep_reply u_rep (
        .clk    (clk),
        .rst_n  (rst_n),
        .tok    (tok_out),
        .rx_stat(rx_stat_w),
        .vld    (reply_vld),
        .code   (code_w)
    );

    assign rx_stat    = rx_stat_w;
    assign tx_stat    = tx_stat_w;
    assign reply_code = code_w;

endmodule

// File: rtl/ep_handshake_chk.sv
module ep_handshake_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tok_out,
    input logic             ev_out_ok,
    input logic             ev_setup_ok,
    input logic             ev_err,
    input logic             sw_flag_we,
    input logic             sw_flag_bit,
    input logic             sw_rx_we,
    input logic             sw_tx_we,
    input logic             reply_vld,
    input logic [1:0]       reply_code,
    input logic [1:0]       rx_stat,
    input logic [1:0]       tx_stat,
    input logic             rx_tog,
    input logic             tx_tog,
    input logic             ctr_flag,
    input logic             setup_flag,
    input logic [CNT_W-1:0] rx_count
);

    logic hw_out, hw_setup, quiet;
    assign hw_out   = ev_out_ok && !ev_setup_ok && !ev_err;
    assign hw_setup = ev_setup_ok && !ev_err;
    assign quiet    = !sw_flag_we && !sw_rx_we && !sw_tx_we;

    p_out_nak_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hw_out |=> (rx_stat == 2'b10) && ctr_flag && !setup_flag && (rx_tog != $past(rx_tog)));

    p_out_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_out && !sw_tx_we) |=> $stable(tx_stat) && $stable(tx_tog));

    p_err_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_err && quiet) |=> $stable(rx_stat) && $stable(tx_stat) && $stable(rx_tog)
                              && $stable(tx_tog) && $stable(ctr_flag) && $stable(setup_flag));

    p_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hw_setup |=> tx_tog && !rx_tog && (rx_stat == 2'b10) && (tx_stat == 2'b10)
                     && ctr_flag && setup_flag);

    p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(hw_out || hw_setup) |=> $stable(rx_count));

    p_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_out && rx_stat == 2'b11) |=> reply_vld && (reply_code == 2'b01));

    p_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tok_out || rx_stat == 2'b00) |=> !reply_vld && (reply_code == 2'b00));

    p_flag_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_flag && !(sw_flag_we && !sw_flag_bit)) |=> ctr_flag);

    p_nak_after_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_out && rx_stat == 2'b10) |=> reply_vld && (reply_code == 2'b10));

endmodule

bind ep_handshake_ctrl ep_handshake_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tok_out    (tok_out),
    .ev_out_ok  (ev_out_ok),
    .ev_setup_ok(ev_setup_ok),
    .ev_err     (ev_err),
    .sw_flag_we (sw_flag_we),
    .sw_flag_bit(sw_flag_bit),
    .sw_rx_we   (sw_rx_we),
    .sw_tx_we   (sw_tx_we),
    .reply_vld  (reply_vld),
    .reply_code (reply_code),
    .rx_stat    (rx_stat),
    .tx_stat    (tx_stat),
    .rx_tog     (rx_tog),
    .tx_tog     (tx_tog),
    .ctr_flag   (ctr_flag),
    .setup_flag (setup_flag),
    .rx_count   (rx_count)
);

// File: tb/sim_ep_handshake_ctrl.sv
`timescale 1ns/1ps
module sim_ep_handshake_ctrl;

    localparam int CW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tok_out = 0, ev_out_ok = 0, ev_setup_ok = 0, ev_err = 0;
    logic [CW-1:0] rx_bytes = '0;
    logic sw_flag_we = 0, sw_flag_bit = 0, sw_rx_we = 0, sw_tx_we = 0;
    logic [1:0] sw_rx_stat = 2'b00, sw_tx_stat = 2'b00;
    logic reply_vld;
    logic [1:0] reply_code, rx_stat, tx_stat;
    logic rx_tog, tx_tog, ctr_flag, setup_flag;
    logic [CW-1:0] rx_count;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    // model state
    logic [1:0] m_rx = 0, m_tx = 0, m_code = 0;
    logic m_rtog = 0, m_ttog = 0, m_ctr = 0, m_setup = 0, m_vld = 0;
    logic [CW-1:0] m_cnt = 0;

    always #2 clk = ~clk;

    ep_handshake_ctrl #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .tok_out(tok_out), .ev_out_ok(ev_out_ok),
        .ev_setup_ok(ev_setup_ok), .ev_err(ev_err), .rx_bytes(rx_bytes),
        .sw_flag_we(sw_flag_we), .sw_flag_bit(sw_flag_bit), .sw_rx_we(sw_rx_we),
        .sw_rx_stat(sw_rx_stat), .sw_tx_we(sw_tx_we), .sw_tx_stat(sw_tx_stat),
        .reply_vld(reply_vld), .reply_code(reply_code), .rx_stat(rx_stat),
        .tx_stat(tx_stat), .rx_tog(rx_tog), .tx_tog(tx_tog), .ctr_flag(ctr_flag),
        .setup_flag(setup_flag), .rx_count(rx_count)
    );

    function automatic logic [1:0] reply_for(input logic [1:0] st);
        case (st)
            2'b11:   return 2'b01;
            2'b10:   return 2'b10;
            2'b01:   return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // advance model with current inputs (called at the rising edge)
    task automatic model_step();
        logic gs, go, dn;
        gs = ev_setup_ok && !ev_err;
        go = ev_out_ok && !ev_setup_ok && !ev_err;
        dn = gs || go;
        m_vld  = tok_out && (m_rx != 2'b00);
        m_code = tok_out ? reply_for(m_rx) : 2'b00;
        if (sw_rx_we) m_rx = sw_rx_stat;
        if (sw_tx_we) m_tx = sw_tx_stat;
        if (sw_flag_we && !sw_flag_bit) m_ctr = 1'b0;
        if (dn) begin
            m_rx = 2'b10; m_ctr = 1'b1; m_setup = gs; m_cnt = rx_bytes;
            m_rtog = gs ? 1'b0 : ~m_rtog;
        end
        if (gs) begin
            m_tx = 2'b10; m_ttog = 1'b1;
        end
    endtask

    task automatic compare_all(input string req);
        check(req, "reply_vld",  int'(reply_vld),  int'(m_vld));
        check(req, "reply_code", int'(reply_code), int'(m_code));
        check(req, "rx_stat",    int'(rx_stat),    int'(m_rx));
        check(req, "tx_stat",    int'(tx_stat),    int'(m_tx));
        check(req, "rx_tog",     int'(rx_tog),     int'(m_rtog));
        check(req, "tx_tog",     int'(tx_tog),     int'(m_ttog));
        check(req, "ctr_flag",   int'(ctr_flag),   int'(m_ctr));
        check(req, "setup_flag", int'(setup_flag), int'(m_setup));
        check(req, "rx_count",   int'(rx_count),   int'(m_cnt));
    endtask

    task automatic idle_inputs();
        tok_out = 0; ev_out_ok = 0; ev_setup_ok = 0; ev_err = 0;
        sw_flag_we = 0; sw_flag_bit = 0; sw_rx_we = 0; sw_tx_we = 0;
    endtask

    // inputs already set after a falling edge; clock one edge and compare
    task automatic tick(input string req);
        @(posedge clk);
        model_step();
        #1;
        compare_all(req);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset values, checked while reset is held
        check("R1", "rx_stat", int'(rx_stat), 0);
        check("R1", "tx_stat", int'(tx_stat), 0);
        check("R1", "toggles", int'({rx_tog, tx_tog}), 0);
        check("R1", "flags", int'({ctr_flag, setup_flag}), 0);
        check("R1", "rx_count", int'(rx_count), 0);
        check("R1", "reply_vld", int'(reply_vld), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8 arm both directions
        sw_rx_we = 1; sw_rx_stat = 2'b11; sw_tx_we = 1; sw_tx_stat = 2'b11;
        tick("R8");
        // R6 VALID answers ACK
        tok_out = 1;
        tick("R6");
        // R2 R5 good OUT
        ev_out_ok = 1; rx_bytes = 10'd64;
        tick("R2");
        check("R5", "rx_count", int'(rx_count), 64);
        // R9 back-to-back tokens NAKed
        tok_out = 1;
        tick("R9");
        check("R9", "reply_code", int'(reply_code), 2);
        tok_out = 1;
        tick("R9");
        // R7 writing 1 keeps flag, writing 0 clears
        sw_flag_we = 1; sw_flag_bit = 1;
        tick("R7");
        check("R7", "ctr_flag kept", int'(ctr_flag), 1);
        sw_flag_we = 1; sw_flag_bit = 0;
        tick("R7");
        check("R7", "ctr_flag cleared", int'(ctr_flag), 0);
        // R9 re-arm then ACK
        sw_rx_we = 1; sw_rx_stat = 2'b11;
        tick("R9");
        tok_out = 1;
        tick("R9");
        check("R9", "reply_code after rearm", int'(reply_code), 1);
        // R3 errored completion has no effect
        ev_out_ok = 1; ev_err = 1; rx_bytes = 10'd99;
        tick("R3");
        ev_setup_ok = 1; ev_err = 1; rx_bytes = 10'd7;
        tick("R3");
        check("R3", "rx_stat held", int'(rx_stat), 3);
        // R6 STALL and DISABLED
        sw_rx_we = 1; sw_rx_stat = 2'b01;
        tick("R8");
        tok_out = 1;
        tick("R6");
        sw_rx_we = 1; sw_rx_stat = 2'b00;
        tick("R8");
        tok_out = 1;
        tick("R6");
        // R4 SETUP, also with OUT in the same cycle
        ev_setup_ok = 1; ev_out_ok = 1; rx_bytes = 10'd8;
        tick("R4");
        check("R4", "tx_tog", int'(tx_tog), 1);
        check("R4", "setup_flag", int'(setup_flag), 1);
        // R7 clear clashing with completion: flag set wins
        ev_out_ok = 1; sw_flag_we = 1; sw_flag_bit = 0; rx_bytes = 10'd3;
        tick("R7");
        check("R7", "ctr_flag clash", int'(ctr_flag), 1);
        // R8 completion beats software rx write, tx write still lands
        ev_out_ok = 1; sw_rx_we = 1; sw_rx_stat = 2'b11; sw_tx_we = 1; sw_tx_stat = 2'b01;
        tick("R8");

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            tok_out     = ($urandom % 3) == 0;
            ev_out_ok   = ($urandom % 6) == 0;
            ev_setup_ok = ($urandom % 12) == 0;
            ev_err      = ($urandom % 5) == 0;
            rx_bytes    = CW'($urandom);
            sw_flag_we  = ($urandom % 5) == 0;
            sw_flag_bit = 1'($urandom);
            sw_rx_we    = ($urandom % 4) == 0;
            sw_rx_stat  = 2'($urandom);
            sw_tx_we    = ($urandom % 6) == 0;
            sw_tx_stat  = 2'($urandom);
            tick("R8");
        end

        done_flag = 1;
        summary();
    end

endmodule